// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for an LCD panel: horizontal and vertical sync, a data-enable qualifier, the running pixel and line counters, and three display interrupt sources. Both axes are described the same way. Every position is measured from the start of sync, which always sits at count 0. The programmed values are the sync end, the display start, the active length and the total.

Software programs the timing words while the generator is disabled, then sets the enable. The current line number is always visible for readback, together with a vsync status and a vblank status. A sticky interrupt status collects three events: the start of a frame, the first displayed line, and a programmable line match. The line match is usually placed at display start plus the active line count. A mask selects which status bits drive the interrupt line, and a write-ones clear vector empties the status.

Top module: `lcd_raster_gen`

## Requirements
- R1: While enabled, `pix_cnt` steps by one each clock and returns to 0 on the cycle after it holds `h_total`-1. `line_cnt` steps only when `pix_cnt` wraps, and returns to 0 after `v_total`-1. Both counters and `line_cnt` are readable at the ports.
- R2: With `enable` low, both counters are held at 0, `de` is low, both sync outputs sit at their inactive level and no interrupt event occurs.
- R3: The horizontal sync is active while `pix_cnt` < `h_sync_end`, and the vertical sync is active while `line_cnt` < `v_sync_end`. `sync_pol[0]` sets the horizontal polarity and `sync_pol[1]` the vertical polarity. A polarity bit of 1 means active-high and 0 means active-low.
- R4: `de` is high exactly when `pix_cnt` lies in [`h_disp_start`, `h_disp_start`+`h_active`) and `line_cnt` lies in [`v_disp_start`, `v_disp_start`+`v_active`).
- R5: `vsync_stat` is high exactly when `line_cnt` < `v_sync_end`, whatever the polarity.
- R6: `vblank_stat` is high when `line_cnt` < `v_disp_start` or `line_cnt` > `v_disp_start`+`v_active`. The line equal to `v_disp_start`+`v_active` therefore reports not blank.
- R7: Interrupt events occur while enabled with `pix_cnt` = 0. Status bit 0 is set by `line_cnt` = 0 (frame start). Bit 1 is set by `line_cnt` = `v_disp_start` (display start). Bit 2 is set by `line_cnt` = `irq_line` (line match). Each bit becomes visible in `irq_status` on the next clock.
- R8: Status bits are sticky. A 1 in `irq_clr` for one cycle clears the matching bit on the next clock. An event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some bit of `irq_status` AND `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the raster; low holds the counters at 0 |
| h_sync_end | input | CW | Pixel where horizontal sync ends |
| h_disp_start | input | CW | First displayed pixel |
| h_active | input | CW | Displayed pixels per line |
| h_total | input | CW | Pixels per line |
| v_sync_end | input | CW | Line where vertical sync ends |
| v_disp_start | input | CW | First displayed line |
| v_active | input | CW | Displayed lines per frame |
| v_total | input | CW | Lines per frame |
| irq_line | input | CW | Line that raises the line-match event |
| sync_pol | input | 2 | Sync polarity, bit 0 horizontal, bit 1 vertical, 1 = active-high |
| irq_mask | input | 3 | Interrupt enable per status bit |
| irq_clr | input | 3 | Write-ones clear pulse per status bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_cnt | output | CW | Current pixel position |
| line_cnt | output | CW | Current line number |
| vsync_stat | output | 1 | Line is inside vertical sync |
| vblank_stat | output | 1 | Line is inside vertical blanking |
| irq_status | output | 3 | Sticky status: bit 0 frame start, bit 1 display start, bit 2 line match |
| irq | output | 1 | Masked interrupt request |

## Verification
Assertions guard the counter mechanics on every cycle: counters hold at zero when idle, step by one, hold between steps and wrap to zero. They also check that a frame wrap lands on the origin, that an event always sets its status bit, that a bit stays set until cleared and that a clear takes effect, and that data enable never coincides with vblank. The window positions only show in the bench's scenarios, since they depend on the programmed values. These include the sync polarities, the inclusive quirk of the vblank line, the priority of an event over a simultaneous clear, and a restart after a disable in mid-frame.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
    localparam int unsigned DEF_CW  = 11;
    localparam int unsigned NUM_IRQ = 3;

    // Status bit positions of the three display interrupt sources.
    typedef enum int unsigned {
        IRQ_FRAME = 0,
        IRQ_DISP  = 1,
        IRQ_MATCH = 2
    } irq_src_e;
endpackage

// File: rtl/lrg_axis.sv
module lrg_axis #(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] total,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] disp_start,
    input  logic [CW-1:0] disp_len,
    output logic [CW-1:0] cnt,
    output logic          carry,
    output logic          in_sync,
    output logic          in_disp
);
    localparam int unsigned EW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ax_st_t;

    ax_st_t        st_d, st_q;
    logic [EW-1:0] inc_ext;
    logic [EW-1:0] disp_end;
    logic          last;

    always_comb begin
        inc_ext  = {1'b0, st_q.cnt} + EW'(1);
        last     = inc_ext >= {1'b0, total};
        disp_end = {1'b0, disp_start} + {1'b0, disp_len};
        st_d     = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = last ? '0 : inc_ext[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign carry   = run & step & last;
    assign in_sync = st_q.cnt < sync_end;
    assign in_disp = ({1'b0, st_q.cnt} >= {1'b0, disp_start}) &&
                     ({1'b0, st_q.cnt} < disp_end);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt == '0)); // R1
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !last) |=> (cnt == $past(cnt) + CW'(1))); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt)); // R1
endmodule

// File: rtl/lrg_irq.sv
module lrg_irq #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] status;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // an event in the same cycle as a clear keeps its bit set
        st_d.status = (st_q.status & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign irq    = |(st_q.status & mask);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((status & $past(ev)) == $past(ev))); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr)) |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~ev)) |=> ((status & $past(clr & ~ev)) == '0)); // R8
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen #(
    parameter int unsigned CW = lrg_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] h_sync_end,
    input  logic [CW-1:0] h_disp_start,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_sync_end,
    input  logic [CW-1:0] v_disp_start,
    input  logic [CW-1:0] v_active,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] irq_line,
    input  logic [1:0]    sync_pol,
    input  logic [2:0]    irq_mask,
    input  logic [2:0]    irq_clr,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] pix_cnt,
    output logic [CW-1:0] line_cnt,
    output logic          vsync_stat,
    output logic          vblank_stat,
    output logic [2:0]    irq_status,
    output logic          irq
);
    import lrg_pkg::*;

    localparam int unsigned EW = CW + 1;

    logic                h_carry, v_carry;
    logic                h_sync_in, v_sync_in;
    logic                h_disp_in, v_disp_in;
    logic [EW-1:0]       v_disp_end;
    logic                at_origin;
    logic [NUM_IRQ-1:0]  ev;

    lrg_axis #(.CW(CW)) i_h_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .step       (1'b1),
        .total      (h_total),
        .sync_end   (h_sync_end),
        .disp_start (h_disp_start),
        .disp_len   (h_active),
        .cnt        (pix_cnt),
        .carry      (h_carry),
        .in_sync    (h_sync_in),
        .in_disp    (h_disp_in)
    );

    lrg_axis #(.CW(CW)) i_v_axis (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .step       (h_carry),
        .total      (v_total),
        .sync_end   (v_sync_end),
        .disp_start (v_disp_start),
        .disp_len   (v_active),
        .cnt        (line_cnt),
        .carry      (v_carry),
        .in_sync    (v_sync_in),
        .in_disp    (v_disp_in)
    );

    always_comb begin
        hsync       = sync_pol[0] ? (enable & h_sync_in) : ~(enable & h_sync_in);
        vsync       = sync_pol[1] ? (enable & v_sync_in) : ~(enable & v_sync_in);
        de          = enable & h_disp_in & v_disp_in;
        vsync_stat  = v_sync_in;
        v_disp_end  = {1'b0, v_disp_start} + {1'b0, v_active};
        vblank_stat = (line_cnt < v_disp_start) || ({1'b0, line_cnt} > v_disp_end);
        at_origin   = enable && (pix_cnt == '0);
        ev          = '0;
        ev[IRQ_FRAME] = at_origin && (line_cnt == '0);
        ev[IRQ_DISP]  = at_origin && (line_cnt == v_disp_start);
        ev[IRQ_MATCH] = at_origin && (line_cnt == irq_line);
    end

    lrg_irq #(.N(NUM_IRQ)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .clr    (irq_clr),
        .mask   (irq_mask),
        .status (irq_status),
        .irq    (irq)
    );

    AST_DE_NOT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !vblank_stat); // R4
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        v_carry |=> ((line_cnt == '0) && (pix_cnt == '0))); // R1
endmodule

// File: tb/test_lcd_raster_gen.sv
module test_lcd_raster_gen;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] h_sync_end = '0, h_disp_start = '0, h_active = '0, h_total = '0;
    logic [CW-1:0] v_sync_end = '0, v_disp_start = '0, v_active = '0, v_total = '0;
    logic [CW-1:0] irq_line = '0;
    logic [1:0]    sync_pol = '0;
    logic [2:0]    irq_mask = '0;
    logic [2:0]    irq_clr = '0;
    logic          hsync, vsync, de, vsync_stat, vblank_stat, irq;
    logic [CW-1:0] pix_cnt, line_cnt;
    logic [2:0]    irq_status;

    int n_chk = 0;
    int n_bad = 0;
    int mh = 0, mv = 0;
    logic [2:0] mst = '0;

    always #2 clk = ~clk;

    lcd_raster_gen #(.CW(CW)) i_lcd_raster_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .h_sync_end(h_sync_end), .h_disp_start(h_disp_start), .h_active(h_active), .h_total(h_total),
        .v_sync_end(v_sync_end), .v_disp_start(v_disp_start), .v_active(v_active), .v_total(v_total),
        .irq_line(irq_line), .sync_pol(sync_pol), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .vsync_stat(vsync_stat), .vblank_stat(vblank_stat), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_de(int h, int v);
        return enable && h >= int'(h_disp_start) && h < int'(h_disp_start) + int'(h_active)
                      && v >= int'(v_disp_start) && v < int'(v_disp_start) + int'(v_active);
    endfunction

    function automatic bit exp_blank(int v);
        return v < int'(v_disp_start) || v > int'(v_disp_start) + int'(v_active);
    endfunction

    task automatic check_all();
        bit hact, vact;
        hact = enable && mh < int'(h_sync_end);
        vact = enable && mv < int'(v_sync_end);
        chk("R1", "pix_cnt", int'(pix_cnt), mh);
        chk("R1", "line_cnt", int'(line_cnt), mv);
        chk("R3", "hsync", int'(hsync), int'(sync_pol[0] ? hact : !hact));
        chk("R3", "vsync", int'(vsync), int'(sync_pol[1] ? vact : !vact));
        chk("R4", "de", int'(de), int'(exp_de(mh, mv)));
        chk("R5", "vsync_stat", int'(vsync_stat), int'(mv < int'(v_sync_end)));
        chk("R6", "vblank_stat", int'(vblank_stat), int'(exp_blank(mv)));
        chk("R7_R8", "irq_status", int'(irq_status), int'(mst));
        chk("R9", "irq", int'(irq), int'(|(mst & irq_mask)));
    endtask

    // clr_mode: 0 none, 1 random, 2 all ones every cycle
    task automatic run_cycles(input int n, input int clr_mode);
        for (int i = 0; i < n; i++) begin
            int nh, nv;
            logic [2:0] ev;
            if (clr_mode == 2)      irq_clr = 3'b111;
            else if (clr_mode == 1) irq_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
            else                    irq_clr = 3'b000;
            if ($urandom_range(0, 15) == 0) irq_mask = 3'($urandom_range(0, 7));
            ev = 3'b000;
            if (!enable) begin
                nh = 0; nv = 0;
            end else begin
                if (mh == 0) begin
                    ev[0] = (mv == 0);
                    ev[1] = (mv == int'(v_disp_start));
                    ev[2] = (mv == int'(irq_line));
                end
                if (mh + 1 >= int'(h_total)) begin
                    nh = 0;
                    nv = (mv + 1 >= int'(v_total)) ? 0 : mv + 1;
                end else begin
                    nh = mh + 1; nv = mv;
                end
            end
            @(negedge clk);
            mst = (mst & ~irq_clr) | ev;
            mh = nh; mv = nv;
            check_all();
        end
        irq_clr = 3'b000;
    endtask

    task automatic set_cfg(int hse, int hds, int ha, int ht, int vse, int vds, int va, int vt, int il);
        h_sync_end = CW'(hse); h_disp_start = CW'(hds); h_active = CW'(ha); h_total = CW'(ht);
        v_sync_end = CW'(vse); v_disp_start = CW'(vds); v_active = CW'(va); v_total = CW'(vt);
        irq_line = CW'(il);
    endtask

    initial begin
        void'($urandom(32'd4242));
        set_cfg(2, 3, 4, 9, 1, 2, 3, 7, 5);
        sync_pol = 2'b00;
        irq_mask = 3'b111;
        repeat (3) @(negedge clk);
        // R2: reset state, disabled
        check_all();
        chk("R2", "reset de", int'(de), 0);
        chk("R2", "reset hsync inactive low-pol", int'(hsync), 1);
        rst_n = 1'b1;
        run_cycles(4, 0);
        chk("R2", "idle status", int'(irq_status), 0);

        // directed frame, active-low syncs, line match at display end (R6 edge line 5)
        enable = 1'b1;
        run_cycles(9 * 7 * 2, 1);
        sync_pol = 2'b11;
        run_cycles(9 * 7, 0);
        // R8: clears every cycle, events still win
        run_cycles(9 * 7, 2);
        // R2: disable in mid-frame, then restart from origin
        run_cycles(13, 1);
        enable = 1'b0;
        run_cycles(5, 1);
        chk("R2", "held line", int'(line_cnt), 0);
        enable = 1'b1;
        run_cycles(30, 0);
        chk("R7", "frame start seen after restart", int'(irq_status[0]), 1);

        // constrained random configurations
        for (int c = 0; c < 12; c++) begin
            int hse, hds, ha, ht, vse, vds, va, vt, il;
            enable = 1'b0;
            run_cycles(2, 0);
            hse = $urandom_range(1, 4);
            hds = hse + $urandom_range(0, 3);
            ha  = $urandom_range(1, 8);
            ht  = hds + ha + $urandom_range(0, 3);
            vse = $urandom_range(1, 3);
            vds = vse + $urandom_range(0, 3);
            va  = $urandom_range(1, 6);
            vt  = vds + va + $urandom_range(0, 3);
            il  = (c % 3 == 0) ? vds + va : $urandom_range(0, vt - 1);
            set_cfg(hse, hds, ha, ht, vse, vds, va, vt, il);
            sync_pol = 2'($urandom_range(0, 3));
            irq_mask = 3'($urandom_range(0, 7));
            enable = 1'b1;
            run_cycles(ht * vt * 2 + $urandom_range(0, 20), (c % 4 == 3) ? 2 : 1);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule